// File: doc/BRIEF.md
# Two-Level Vectored Interrupt Controller

This block gathers twelve interrupt sources for an 8-bit controller core and hands the core one vector at a time. Four sources come from logic elsewhere on the die: two external-interrupt flags and two timer-overflow flags. Each arrives as a level that its owner holds until the handler clears it. The other eight sources are the port-1 pins. Each pin passes through a synchroniser and is compared against a programmable polarity. The match sets a sticky request flag, which only software can clear.

Software sets up the block through a small register port. The port covers per-source enables and a global enable, a bit per source that picks the high or the low level, the pin polarity, and the pin flags. The winning request is offered to the core as a vector address on a valid/ready channel. An accepted offer marks its level as active, so nesting works, and a return pulse from the core retires the most recent level. A separate wake output follows the raw pins without any clock, so a stopped core can be restarted.

Channel rules: once `irq_valid` rises, `irq_vector` and `irq_high` stay fixed until the cycle in which `irq_ready` is high. That cycle is the transfer. `irq_valid` is low in the following cycle, and no new offer loads in that cycle. The core may hold `irq_ready` low for any number of cycles. A request that arrives while an offer waits does not replace it.

Top module: `irqc_top`

## Requirements
- R1: After reset all six registers read 0, `irq_valid` is 0, `act_level` is 2'b00 and `wake` is 0.
- R2: The register addresses are 0 enable-A, 1 enable-B, 2 level-A, 3 level-B, 4 polarity and 5 flags. In enable-A, bit 7 is the global enable and bits 0..3 are INT0, T0, INT1 and T1. In level-A, bits 0..3 cover the same sources. Bit k of enable-B, level-B, polarity and flags belongs to pin k, which is source INT(k+2). Writes read back, and the unused bits of enable-A and level-A read 0.
- R3: A pin flag sets when the synchronised pin equals its polarity bit (1 = active high, 0 = active low). This happens whether or not the source is enabled.
- R4: Writing 0 to a flag bit clears it. Writing 1 leaves it unchanged. Hardware never clears a flag.
- R5: A source requests only while its own enable bit and the global enable are both 1.
- R6: The vectors are 0x0003, 0x000B, 0x0013 and 0x001B for INT0, T0, INT1 and T1, and 0x003B + 8*k for pin k.
- R7: Among requests at the same level, the order from first to last is INT0, INT5, T0, INT6, INT1, INT2, INT7, T1, INT3, INT8, INT4, INT9.
- R8: A high-level request wins over any low-level request, regardless of the order in R7.
- R9: While a low level is active, only high-level requests are offered. While a high level is active, nothing is offered.
- R10: A transfer (valid and ready) marks the offered level active. The offer stays unchanged while it waits under back-pressure.
- R11: A return pulse retires the high level if it is active, otherwise the low level. A flag still set afterwards is offered again.
- R12: `wake` is 1 whenever an enabled pin is at its active level, taken from the raw pin with no clock involved.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr (combinational) |
| core_req | input | 4 | Held requests: bit 0 INT0, 1 T0, 2 INT1, 3 T1 |
| port_pin | input | 8 | Raw port-1 pins |
| irq_valid | output | 1 | Vector offer valid |
| irq_ready | input | 1 | Core accepts the offer |
| irq_vector | output | 16 | Vector address of the offer |
| irq_high | output | 1 | Offer belongs to the high level |
| irq_return | input | 1 | Return-from-interrupt pulse |
| act_level | output | 2 | Active levels: bit 1 high, bit 0 low |
| wake | output | 1 | Asynchronous wake request |

## Verification
The bench builds the block with its default two-flop synchroniser and all twelve sources. That small size makes a full sweep practical: every unordered source pair, including each source alone, is run under all four high/low assignments, and the bench works out the expected winner from the fixed order and the level rule. Directed sequences cover the pin polarity, the flag write rule, back-pressure, nesting, return and re-offer, and the clockless wake path.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int NUM_PINS = 8;
  localparam int NUM_CORE = 4;
  localparam int NUM_SRC  = NUM_PINS + NUM_CORE;
  localparam int SRC_W    = $clog2(NUM_SRC);
  localparam int VEC_W    = 16;

  localparam logic [2:0] A_ENA0 = 3'd0;
  localparam logic [2:0] A_ENA1 = 3'd1;
  localparam logic [2:0] A_PRI0 = 3'd2;
  localparam logic [2:0] A_PRI1 = 3'd3;
  localparam logic [2:0] A_POL  = 3'd4;
  localparam logic [2:0] A_FLAG = 3'd5;

  // Source ids: 0 INT0, 1 T0, 2 INT1, 3 T1, 4+k pin k.
  // Maps a position in the fixed same-level order to its source id.
  function automatic logic [SRC_W-1:0] rank_src(input int unsigned rank);
    logic [SRC_W-1:0] id;
    case (rank)
      0:  id = 4'd0;
      1:  id = 4'd7;
      2:  id = 4'd1;
      3:  id = 4'd8;
      4:  id = 4'd2;
      5:  id = 4'd4;
      6:  id = 4'd9;
      7:  id = 4'd3;
      8:  id = 4'd5;
      9:  id = 4'd10;
      10: id = 4'd6;
      default: id = 4'd11;
    endcase
    return id;
  endfunction

  function automatic logic [VEC_W-1:0] src_vector(input logic [SRC_W-1:0] id);
    logic [VEC_W-1:0] v;
    if (id < SRC_W'(NUM_CORE)) v = 16'h0003 + VEC_W'(id) * 16'd8;
    else                       v = 16'h003B + (VEC_W'(id) - 16'd4) * 16'd8;
    return v;
  endfunction
endpackage

// File: rtl/irqc_sync.sv
module irqc_sync #(
  parameter int WIDTH = 8,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RESET_VAL = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] chain [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[s] <= RESET_VAL;
        else if (s == 0) chain[s] <= d;
        else chain[s] <= chain[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/irqc_regs.sv
module irqc_regs
  import irqc_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr,
  input  logic [2:0]          addr,
  input  logic [7:0]          wdata,
  input  logic [NUM_PINS-1:0] pin_sync,
  output logic [7:0]          rdata,
  output logic                glob_en,
  output logic [NUM_CORE-1:0] core_en,
  output logic [NUM_PINS-1:0] pin_en,
  output logic [NUM_CORE-1:0] core_hi,
  output logic [NUM_PINS-1:0] pin_hi,
  output logic [NUM_PINS-1:0] pin_pol,
  output logic [NUM_PINS-1:0] pin_flag
);
  logic [NUM_PINS-1:0] flag_n;

  always_comb begin
    flag_n = pin_flag;
    if (wr && addr == A_FLAG) flag_n = pin_flag & wdata;
    flag_n = flag_n | ~(pin_sync ^ pin_pol);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      glob_en  <= 1'b0;
      core_en  <= '0;
      pin_en   <= '0;
      core_hi  <= '0;
      pin_hi   <= '0;
      pin_pol  <= '0;
      pin_flag <= '0;
    end else begin
      pin_flag <= flag_n;
      if (wr) begin
        case (addr)
          A_ENA0: begin
            glob_en <= wdata[7];
            core_en <= wdata[NUM_CORE-1:0];
          end
          A_ENA1: pin_en  <= wdata;
          A_PRI0: core_hi <= wdata[NUM_CORE-1:0];
          A_PRI1: pin_hi  <= wdata;
          A_POL:  pin_pol <= wdata;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (addr)
      A_ENA0:  rdata = {glob_en, 3'b000, core_en};
      A_ENA1:  rdata = pin_en;
      A_PRI0:  rdata = {4'b0000, core_hi};
      A_PRI1:  rdata = pin_hi;
      A_POL:   rdata = pin_pol;
      A_FLAG:  rdata = pin_flag;
      default: rdata = 8'h00;
    endcase
  end
endmodule

// File: rtl/irqc_arbiter.sv
module irqc_arbiter
  import irqc_pkg::*;
(
  input  logic [NUM_SRC-1:0] pend,
  input  logic [NUM_SRC-1:0] hi_sel,
  input  logic               allow_hi,
  input  logic               allow_lo,
  output logic               found,
  output logic [SRC_W-1:0]   win_id,
  output logic               win_high
);
  logic [NUM_SRC-1:0] rank_hi, rank_lo;
  logic any_hi;

  generate
    for (genvar r = 0; r < NUM_SRC; r++) begin : g_rank
      localparam logic [SRC_W-1:0] SID = rank_src(r);
      assign rank_hi[r] = pend[SID] &  hi_sel[SID];
      assign rank_lo[r] = pend[SID] & ~hi_sel[SID];
    end
  endgenerate

  assign any_hi = allow_hi && (|rank_hi);

  always_comb begin
    found    = 1'b0;
    win_id   = '0;
    win_high = any_hi;
    for (int r = NUM_SRC - 1; r >= 0; r--) begin
      if (any_hi ? rank_hi[r] : (allow_lo && rank_lo[r])) begin
        found  = 1'b1;
        win_id = rank_src(r);
      end
    end
  end
endmodule

// File: rtl/irqc_level.sv
module irqc_level (
  input  logic clk,
  input  logic rst_n,
  input  logic push,
  input  logic push_high,
  input  logic pop,
  output logic act_hi,
  output logic act_lo
);
  logic nxt_hi, nxt_lo;

  always_comb begin
    nxt_hi = act_hi;
    nxt_lo = act_lo;
    if (pop) begin
      if (act_hi) nxt_hi = 1'b0;
      else        nxt_lo = 1'b0;
    end
    if (push) begin
      if (push_high) nxt_hi = 1'b1;
      else           nxt_lo = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_hi <= 1'b0;
      act_lo <= 1'b0;
    end else begin
      act_hi <= nxt_hi;
      act_lo <= nxt_lo;
    end
  end
endmodule

// File: rtl/irqc_top.sv
module irqc_top
  import irqc_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_wr,
  input  logic [2:0]          reg_addr,
  input  logic [7:0]          reg_wdata,
  output logic [7:0]          reg_rdata,
  input  logic [NUM_CORE-1:0] core_req,
  input  logic [NUM_PINS-1:0] port_pin,
  output logic                irq_valid,
  input  logic                irq_ready,
  output logic [VEC_W-1:0]    irq_vector,
  output logic                irq_high,
  input  logic                irq_return,
  output logic [1:0]          act_level,
  output logic                wake
);
  logic [NUM_PINS-1:0] pin_sync, pin_en, pin_hi, pin_pol, pin_flag;
  logic [NUM_CORE-1:0] core_en, core_hi;
  logic                glob_en;
  logic [NUM_SRC-1:0]  pend, hi_sel;
  logic                found, win_high, act_hi, act_lo;
  logic [SRC_W-1:0]    win_id;

  irqc_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES), .RESET_VAL('1)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(port_pin), .q(pin_sync)
  );

  irqc_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .pin_sync(pin_sync), .rdata(reg_rdata), .glob_en(glob_en), .core_en(core_en),
    .pin_en(pin_en), .core_hi(core_hi), .pin_hi(pin_hi), .pin_pol(pin_pol),
    .pin_flag(pin_flag)
  );

  assign pend   = {pin_flag & pin_en, core_req & core_en} & {NUM_SRC{glob_en}};
  assign hi_sel = {pin_hi, core_hi};

  irqc_arbiter u_arb (
    .pend(pend), .hi_sel(hi_sel), .allow_hi(!act_hi), .allow_lo(!act_hi && !act_lo),
    .found(found), .win_id(win_id), .win_high(win_high)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_valid  <= 1'b0;
      irq_vector <= '0;
      irq_high   <= 1'b0;
    end else if (irq_valid && irq_ready) begin
      irq_valid <= 1'b0;
    end else if (!irq_valid && found) begin
      irq_valid  <= 1'b1;
      irq_vector <= src_vector(win_id);
      irq_high   <= win_high;
    end
  end

  irqc_level u_level (
    .clk(clk), .rst_n(rst_n), .push(irq_valid && irq_ready), .push_high(irq_high),
    .pop(irq_return), .act_hi(act_hi), .act_lo(act_lo)
  );

  assign act_level = {act_hi, act_lo};
  assign wake      = |(pin_en & ~(port_pin ^ pin_pol));
endmodule

// File: rtl/irqc_checker.sv
module irqc_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        irq_valid,
  input logic        irq_ready,
  input logic [15:0] irq_vector,
  input logic        irq_high,
  input logic        irq_return,
  input logic [1:0]  act_level,
  input logic        reg_wr,
  input logic [2:0]  reg_addr,
  input logic [7:0]  flags
);
  p_hold_offer_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid && !irq_ready |=> irq_valid && $stable(irq_vector) && $stable(irq_high));

  p_level_mark_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid && irq_ready && !irq_return |=> ($past(irq_high) ? act_level[1] : act_level[0]));

  p_nest_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> !act_level[1] && (!act_level[0] || irq_high));

  p_pop_high_r11: assert property (@(posedge clk) disable iff (!rst_n)
    irq_return && act_level[1] && !(irq_valid && irq_ready)
    |=> !act_level[1] && (act_level[0] == $past(act_level[0])));

  p_flag_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && reg_addr == 3'd5) |=> ((flags & $past(flags)) == $past(flags)));

  p_vec_form_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> irq_vector[2:0] == 3'b011 && irq_vector[15:7] == 9'd0);
endmodule

bind irqc_top irqc_checker u_chk (
  .clk(clk), .rst_n(rst_n), .irq_valid(irq_valid), .irq_ready(irq_ready),
  .irq_vector(irq_vector), .irq_high(irq_high), .irq_return(irq_return),
  .act_level(act_level), .reg_wr(reg_wr), .reg_addr(reg_addr), .flags(pin_flag)
);

// File: tb/irqc_top_tb.sv
`timescale 1ns/1ps
module irqc_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = 3'd0;
  logic [7:0]  reg_wdata = 8'd0;
  logic [7:0]  reg_rdata;
  logic [3:0]  core_req = 4'd0;
  logic [7:0]  port_pin = 8'hFF;
  logic        irq_valid, irq_high, wake;
  logic        irq_ready = 1'b0;
  logic        irq_return = 1'b0;
  logic [15:0] irq_vector;
  logic [1:0]  act_level;
  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  irqc_top dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .core_req(core_req),
    .port_pin(port_pin), .irq_valid(irq_valid), .irq_ready(irq_ready),
    .irq_vector(irq_vector), .irq_high(irq_high), .irq_return(irq_return),
    .act_level(act_level), .wake(wake)
  );

  int rank_of [12] = '{0, 2, 4, 7, 5, 8, 10, 1, 3, 6, 9, 11};

  function automatic logic [15:0] exp_vec(input int id);
    return (id < 4) ? 16'(3 + 8 * id) : 16'(59 + 8 * (id - 4));
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic accept();
    @(negedge clk); irq_ready = 1'b1;
    @(negedge clk); irq_ready = 1'b0;
  endtask

  task automatic ret();
    @(negedge clk); irq_return = 1'b1;
    @(negedge clk); irq_return = 1'b0;
  endtask

  // Pins run active high (polarity FF) during the sweep.
  task automatic set_src(input int id, input logic on);
    if (id < 4) core_req[id] = on;
    else port_pin[id-4] = on;
  endtask

  task automatic run_case(input int a, input int b, input bit ha, input bit hb);
    logic [7:0] en0, en1, p0, p1;
    int w;
    bit wh;
    en0 = 0; en1 = 0; p0 = 0; p1 = 0;
    if (a < 4) begin en0[a] = 1; p0[a] = ha; end
    else begin en1[a-4] = 1; p1[a-4] = ha; end
    if (b < 4) begin en0[b] = 1; if (b != a) p0[b] = hb; end
    else begin en1[b-4] = 1; if (b != a) p1[b-4] = hb; end
    if (a == b) begin w = a; wh = ha; end
    else if (ha != hb) begin w = ha ? a : b; wh = 1'b1; end
    else begin w = (rank_of[a] < rank_of[b]) ? a : b; wh = ha; end
    wr(3'd0, 8'h00); wr(3'd2, p0); wr(3'd3, p1);
    set_src(a, 1'b1); set_src(b, 1'b1);
    idle(4);
    wr(3'd1, en1); wr(3'd0, 8'h80 | en0);
    idle(3);
    check(irq_valid && irq_vector == exp_vec(w) && irq_high == wh,
          (ha != hb) ? "R8 level wins" : "R7 same-level order",
          {irq_valid, irq_high, 14'd0, irq_vector}, {1'b1, wh, 14'd0, exp_vec(w)});
    accept();
    wr(3'd0, 8'h00); wr(3'd1, 8'h00);
    ret();
    set_src(a, 1'b0); set_src(b, 1'b0);
    idle(4);
    wr(3'd5, 8'h00);
    idle(2);
  endtask

  initial begin
    logic [7:0] d;
    idle(4);
    rst_n = 1'b1;
    idle(2);
    // R1 reset state
    for (int a = 0; a < 6; a++) begin
      rd(3'(a), d);
      check(d == 8'h00, "R1 register reset", 32'(d), 32'h0);
    end
    check(!irq_valid && act_level == 2'b00 && !wake, "R1 outputs reset",
          {28'd0, irq_valid, act_level, wake}, 32'h0);
    // R2 readback and masks
    for (int a = 0; a < 5; a++) begin
      wr(3'(a), 8'hA5);
      rd(3'(a), d);
      check(d == ((a == 0) ? 8'h85 : (a == 2) ? 8'h05 : 8'hA5), "R2 readback",
            32'(d), (a == 0) ? 32'h85 : (a == 2) ? 32'h05 : 32'hA5);
      wr(3'(a), 8'h00);
    end
    wr(3'd5, 8'h00);
    rd(3'd5, d);
    check(d == 8'h00, "R4 flags cleared after R2 pass", 32'(d), 32'h0);
    // R3 active-low detection with polarity 0
    port_pin[2] = 1'b0;
    idle(4);
    rd(3'd5, d);
    check(d == 8'h04, "R3 active-low flag", 32'(d), 32'h04);
    wr(3'd5, 8'hFF);
    rd(3'd5, d);
    check(d == 8'h04, "R4 write one no effect", 32'(d), 32'h04);
    port_pin[2] = 1'b1;
    idle(4);
    rd(3'd5, d);
    check(d == 8'h04, "R4 no hardware clear", 32'(d), 32'h04);
    wr(3'd5, 8'hFB);
    rd(3'd5, d);
    check(d == 8'h00, "R4 write zero clears", 32'(d), 32'h0);
    // R12 wake follows raw pin, R5 global gate
    wr(3'd1, 8'h04);
    @(negedge clk);
    check(!wake, "R12 wake idle", 32'(wake), 32'h0);
    port_pin[2] = 1'b0;
    #0.5;
    check(wake, "R12 wake without clock edge", 32'(wake), 32'h1);
    idle(5);
    check(!irq_valid, "R5 global enable off", 32'(irq_valid), 32'h0);
    port_pin[2] = 1'b1;
    #0.5;
    check(!wake, "R12 wake drops", 32'(wake), 32'h0);
    wr(3'd1, 8'h00);
    wr(3'd5, 8'h00);
    wr(3'd0, 8'h80);
    core_req = 4'b0010;
    idle(4);
    check(!irq_valid, "R5 source enable off", 32'(irq_valid), 32'h0);
    core_req = 4'b0000;
    wr(3'd0, 8'h00);
    // Switch pins to active high
    wr(3'd4, 8'hFF);
    port_pin = 8'h00;
    idle(4);
    wr(3'd5, 8'h00);
    rd(3'd5, d);
    check(d == 8'h00, "R3 active-high idle", 32'(d), 32'h0);
    port_pin[5] = 1'b1;
    idle(4);
    rd(3'd5, d);
    check(d == 8'h20, "R3 active-high flag", 32'(d), 32'h20);
    port_pin[5] = 1'b0;
    wr(3'd5, 8'h00);
    // Sweep every pair under every level assignment (R6 R7 R8)
    for (int a = 0; a < 12; a++)
      for (int b = a; b < 12; b++)
        for (int pc = 0; pc < 4; pc++)
          run_case(a, b, pc[0], pc[1]);
    // Back-pressure, nesting, return (R9 R10 R11)
    wr(3'd2, 8'h00); wr(3'd3, 8'h00);
    wr(3'd1, 8'h80); wr(3'd0, 8'h81);
    port_pin[7] = 1'b1;
    idle(5);
    check(irq_valid && irq_vector == 16'h0073, "R6 INT9 vector offered",
          32'(irq_vector), 32'h73);
    core_req[0] = 1'b1;
    idle(5);
    check(irq_valid && irq_vector == 16'h0073, "R10 offer held under back-pressure",
          32'(irq_vector), 32'h73);
    accept();
    check(act_level == 2'b01 && !irq_valid, "R10 low level marked",
          {30'd0, act_level}, 32'h1);
    idle(3);
    check(!irq_valid, "R9 low not offered during low", 32'(irq_valid), 32'h0);
    wr(3'd2, 8'h01);
    idle(3);
    check(irq_valid && irq_high && irq_vector == 16'h0003, "R9 high preempts low",
          32'(irq_vector), 32'h3);
    accept();
    check(act_level == 2'b11, "R10 high level marked", {30'd0, act_level}, 32'h3);
    core_req[0] = 1'b0;
    port_pin[7] = 1'b0;
    idle(3);
    check(!irq_valid, "R9 nothing during high", 32'(irq_valid), 32'h0);
    ret();
    check(act_level == 2'b01, "R11 return pops high first", {30'd0, act_level}, 32'h1);
    idle(3);
    check(!irq_valid, "R9 still low active", 32'(irq_valid), 32'h0);
    ret();
    check(act_level == 2'b00, "R11 return pops low", {30'd0, act_level}, 32'h0);
    idle(3);
    check(irq_valid && irq_vector == 16'h0073 && !irq_high, "R11 set flag taken again",
          32'(irq_vector), 32'h73);
    accept();
    wr(3'd0, 8'h00);
    ret();
    wr(3'd5, 8'h00);
    idle(3);
    check(!irq_valid && act_level == 2'b00, "R11 quiet after clear",
          {29'd0, irq_valid, act_level}, 32'h0);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule